// File: doc/BRIEF.md
# Serial Status Flag Register

This block holds the eight status and control flags of an asynchronous serial port. The transmitter and the receiver report what happens to them through single-cycle event pulses: a character has moved into the transmit shifter, the last bit of a character has gone out, or a frame has arrived, perhaps with a framing or parity fault. The block turns those pulses into sticky flags. A processor reads the flags as one byte and clears them through a guarded write.

A flag that software may clear is only cleared by writing a zero to its bit after a status read has returned that bit as one. A write of zero to a flag that software never saw set leaves it alone. This keeps an event that arrives between the read and the write from being lost. DMA accesses to the transmit and receive data registers appear as strobes, and they clear the data flags directly. The block also holds one plain read/write bit: the multiprocessor bit that goes out with the next transmitted character.

Top module: `serial_flag_reg`

## Requirements
- R1: After a synchronous reset the status word reads 8'h84: transmit-empty and transmit-done are 1 and every other bit is 0.
- R2: `cpu_rdata` always shows the current flags at fixed bit positions: 7 transmit-empty, 6 receive-full, 5 overrun, 4 framing error, 3 parity error, 2 transmit-done, 1 received multiprocessor bit, 0 multiprocessor bit to send.
- R3: Bits 7 to 3 are cleared by a `cpu_wr` whose data bit is 0 only when a `cpu_rd` since the previous write found that bit at 1. A write of 1 to these bits has no effect. Every write disarms all five bits, whatever data it carries.
- R4: Transmit-empty is 1 in the cycle after any cycle with `tx_en` low. It is set by `tx_load`. It is cleared by a qualified zero-write to bit 7 or by `dma_txd_wr`.
- R5: Transmit-done is set by `tx_last_bit` only while transmit-empty is 1. It is forced to 1 while `tx_en` is low. It is cleared by the same two events that clear transmit-empty, and writes to bit 2 are ignored.
- R6: Receive-full is set by `rx_done` when neither fault input is high and receive-full is 0. It is cleared by a qualified zero-write to bit 6 or by `dma_rxd_rd`.
- R7: Overrun is set by `rx_done` while receive-full is 1.
- R8: Framing error and parity error are set by `rx_done` together with `rx_frame_err` and `rx_parity_err` respectively.
- R9: The received multiprocessor bit takes the value of `rx_mpbit` on every `rx_done`. Writes to bit 1 are ignored.
- R10: The multiprocessor bit to send takes `cpu_wdata[0]` on every write.
- R11: If a set event and a clear for the same flag fall in one cycle, the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Transmitter enable; low forces transmit-empty and transmit-done |
| cpu_rd | input | 1 | Status read strobe; arms the flags it sees at 1 |
| cpu_wr | input | 1 | Status write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Current status word |
| tx_load | input | 1 | Pulse: data moved from the transmit buffer to the shifter |
| tx_last_bit | input | 1 | Pulse: last bit of a character sent |
| rx_done | input | 1 | Pulse: a frame finished arriving |
| rx_frame_err | input | 1 | Qualifies rx_done: stop bit was 0 |
| rx_parity_err | input | 1 | Qualifies rx_done: parity mismatch |
| rx_mpbit | input | 1 | Qualifies rx_done: received multiprocessor bit |
| dma_txd_wr | input | 1 | Pulse: DMA wrote the transmit data register |
| dma_rxd_rd | input | 1 | Pulse: DMA read the receive data register |

## Verification
The block has no tunable parameters, so the bench builds it with its single fixed 8-bit layout and five guarded flags. That layout puts every interaction in reach of a short random run. Arming and disarming race against set events. Overrun depends on the receive-full state, transmit-done depends on transmit-empty, and the transmitter can be disabled in the middle of a clear. Directed sequences first pin down the guarded clear, the set-over-clear priority and the forced flags at known values.

// File: rtl/sflag_pkg.sv
package sflag_pkg;

    localparam int REG_W    = 8;
    localparam int NCLR     = 5;
    localparam int CLR_BASE = 3;

    localparam int B_TXE = 7;
    localparam int B_RXF = 6;
    localparam int B_OVR = 5;
    localparam int B_FRM = 4;
    localparam int B_PAR = 3;
    localparam int B_TXD = 2;
    localparam int B_RMP = 1;
    localparam int B_TMP = 0;

    localparam int I_TXE = B_TXE - CLR_BASE;
    localparam int I_RXF = B_RXF - CLR_BASE;
    localparam int I_OVR = B_OVR - CLR_BASE;
    localparam int I_FRM = B_FRM - CLR_BASE;
    localparam int I_PAR = B_PAR - CLR_BASE;

    localparam logic [REG_W-1:0] RST_WORD = 8'h84;

    typedef struct packed {
        logic tx_load;
        logic tx_last;
        logic rx_done;
        logic rx_fe;
        logic rx_pe;
        logic rx_mpb;
        logic dma_tx_wr;
        logic dma_rx_rd;
    } sflag_evt_t;

    function automatic logic clean_frame(input sflag_evt_t e);
        return e.rx_done && !e.rx_fe && !e.rx_pe;
    endfunction

endpackage

// File: rtl/sflag_cell.sv
module sflag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic xclr_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic q_o,
    output logic wclr_o
);

    logic q;
    logic arm;

    assign wclr_o = wr_i && !wbit_i && arm;
    assign q_o    = q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= RST_VAL;
            arm <= 1'b0;
        end else begin
            if (set_i)
                q <= 1'b1;
            else if (wclr_o || xclr_i)
                q <= 1'b0;
            if (wr_i)
                arm <= 1'b0;
            else if (rd_i && q)
                arm <= 1'b1;
        end
    end

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q);

    assert_unarmed_write_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !arm && !set_i && !xclr_i && q) |=> q);

    assert_write_disarms_R3: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> !arm);

endmodule

// File: rtl/sflag_set_gen.sv
module sflag_set_gen
    import sflag_pkg::*;
(
    input  sflag_evt_t        evt_i,
    input  logic              tx_en_i,
    input  logic              txe_q_i,
    input  logic              rxf_q_i,
    output logic [NCLR-1:0]   set_o,
    output logic [NCLR-1:0]   xclr_o,
    output logic              txd_set_o
);

    always_comb begin
        set_o        = '0;
        xclr_o       = '0;
        set_o[I_TXE] = !tx_en_i || evt_i.tx_load;
        set_o[I_RXF] = clean_frame(evt_i) && !rxf_q_i;
        set_o[I_OVR] = evt_i.rx_done && rxf_q_i;
        set_o[I_FRM] = evt_i.rx_done && evt_i.rx_fe;
        set_o[I_PAR] = evt_i.rx_done && evt_i.rx_pe;
        xclr_o[I_TXE] = evt_i.dma_tx_wr;
        xclr_o[I_RXF] = evt_i.dma_rx_rd;
        txd_set_o    = !tx_en_i || (evt_i.tx_last && txe_q_i);
    end

endmodule

// File: rtl/serial_flag_reg.sv
module serial_flag_reg
    import sflag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_en,
    input  logic             cpu_rd,
    input  logic             cpu_wr,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    input  logic             tx_load,
    input  logic             tx_last_bit,
    input  logic             rx_done,
    input  logic             rx_frame_err,
    input  logic             rx_parity_err,
    input  logic             rx_mpbit,
    input  logic             dma_txd_wr,
    input  logic             dma_rxd_rd
);

    sflag_evt_t       evt;
    logic [NCLR-1:0]  set_v;
    logic [NCLR-1:0]  xclr_v;
    logic [NCLR-1:0]  q_v;
    logic [NCLR-1:0]  wclr_v;
    logic             txd_set;
    logic             txd_q;
    logic             rmp_q;
    logic             tmp_q;
    logic             unused_wbits;

    assign unused_wbits = ^cpu_wdata[B_TXD:B_RMP];

    always_comb begin
        evt.tx_load   = tx_load;
        evt.tx_last   = tx_last_bit;
        evt.rx_done   = rx_done;
        evt.rx_fe     = rx_frame_err;
        evt.rx_pe     = rx_parity_err;
        evt.rx_mpb    = rx_mpbit;
        evt.dma_tx_wr = dma_txd_wr;
        evt.dma_rx_rd = dma_rxd_rd;
    end

    sflag_set_gen u_set_gen (
        .evt_i     (evt),
        .tx_en_i   (tx_en),
        .txe_q_i   (q_v[I_TXE]),
        .rxf_q_i   (q_v[I_RXF]),
        .set_o     (set_v),
        .xclr_o    (xclr_v),
        .txd_set_o (txd_set)
    );

    for (genvar i = 0; i < NCLR; i++) begin : g_cell
        sflag_cell #(
            .RST_VAL (RST_WORD[CLR_BASE+i])
        ) u_cell (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_v[i]),
            .xclr_i (xclr_v[i]),
            .rd_i   (cpu_rd),
            .wr_i   (cpu_wr),
            .wbit_i (cpu_wdata[CLR_BASE+i]),
            .q_o    (q_v[i]),
            .wclr_o (wclr_v[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            txd_q <= RST_WORD[B_TXD];
            rmp_q <= RST_WORD[B_RMP];
            tmp_q <= RST_WORD[B_TMP];
        end else begin
            if (txd_set)
                txd_q <= 1'b1;
            else if (wclr_v[I_TXE] || evt.dma_tx_wr)
                txd_q <= 1'b0;
            if (evt.rx_done)
                rmp_q <= evt.rx_mpb;
            if (cpu_wr)
                tmp_q <= cpu_wdata[B_TMP];
        end
    end

    assign cpu_rdata = {q_v, txd_q, rmp_q, tmp_q};

    assert_idle_forces_tx_flags_R4: assert property (@(posedge clk) disable iff (rst)
        !tx_en |=> (cpu_rdata[B_TXE] && cpu_rdata[B_TXD]));

    assert_done_needs_empty_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_en && !cpu_rdata[B_TXE] && !cpu_rdata[B_TXD]) |=> !cpu_rdata[B_TXD]);

    assert_overrun_R7: assert property (@(posedge clk) disable iff (rst)
        (rx_done && cpu_rdata[B_RXF]) |=> cpu_rdata[B_OVR]);

    assert_mpbit_follows_R9: assert property (@(posedge clk) disable iff (rst)
        rx_done |=> (cpu_rdata[B_RMP] == $past(rx_mpbit)));

    assert_send_bit_R10: assert property (@(posedge clk) disable iff (rst)
        cpu_wr |=> (cpu_rdata[B_TMP] == $past(cpu_wdata[B_TMP])));

endmodule

// File: tb/serial_flag_reg_bench.sv
module serial_flag_reg_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_en = 1'b1;
    logic       cpu_rd = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic       tx_load = 1'b0;
    logic       tx_last_bit = 1'b0;
    logic       rx_done = 1'b0;
    logic       rx_frame_err = 1'b0;
    logic       rx_parity_err = 1'b0;
    logic       rx_mpbit = 1'b0;
    logic       dma_txd_wr = 1'b0;
    logic       dma_rxd_rd = 1'b0;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    bit m[8];
    bit marm[8];
    string tag[8] = '{"R10", "R9", "R5", "R8", "R8", "R7", "R6", "R4"};

    always #10 clk = ~clk;

    serial_flag_reg u_serial_flag_reg (
        .clk(clk), .rst(rst), .tx_en(tx_en), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tx_load(tx_load),
        .tx_last_bit(tx_last_bit), .rx_done(rx_done), .rx_frame_err(rx_frame_err),
        .rx_parity_err(rx_parity_err), .rx_mpbit(rx_mpbit),
        .dma_txd_wr(dma_txd_wr), .dma_rxd_rd(dma_rxd_rd)
    );

    function automatic logic [7:0] model_word();
        logic [7:0] w;
        for (int k = 0; k < 8; k++) w[k] = m[k];
        return w;
    endfunction

    task automatic model_step();
        bit old[8];
        bit wc[8];
        old = m;
        if (rst) begin
            for (int k = 0; k < 8; k++) begin m[k] = (k == 7 || k == 2); marm[k] = 0; end
            return;
        end
        for (int k = 0; k < 8; k++) wc[k] = (k >= 3) && cpu_wr && !cpu_wdata[k] && marm[k];
        if (!tx_en || tx_load) m[7] = 1; else if (wc[7] || dma_txd_wr) m[7] = 0;
        if (!tx_en || (tx_last_bit && old[7])) m[2] = 1; else if (wc[7] || dma_txd_wr) m[2] = 0;
        if (rx_done && !rx_frame_err && !rx_parity_err && !old[6]) m[6] = 1;
        else if (wc[6] || dma_rxd_rd) m[6] = 0;
        if (rx_done && old[6]) m[5] = 1; else if (wc[5]) m[5] = 0;
        if (rx_done && rx_frame_err) m[4] = 1; else if (wc[4]) m[4] = 0;
        if (rx_done && rx_parity_err) m[3] = 1; else if (wc[3]) m[3] = 0;
        if (rx_done) m[1] = rx_mpbit;
        if (cpu_wr) m[0] = cpu_wdata[0];
        for (int k = 3; k < 8; k++) begin
            if (cpu_wr) marm[k] = 0;
            else if (cpu_rd && old[k]) marm[k] = 1;
        end
    endtask

    task automatic compare_model();
        logic [7:0] e;
        e = model_word();
        compared++;
        if (cpu_rdata !== e) begin
            mismatched++;
            for (int k = 0; k < 8; k++)
                if (cpu_rdata[k] !== e[k])
                    $display("FAIL %s bit %0d: actual %b expected %b (word %h vs %h)",
                             tag[k], k, cpu_rdata[k], e[k], cpu_rdata, e);
        end
    endtask

    task automatic check_word(input logic [7:0] exp, input string req);
        compared++;
        if (cpu_rdata !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", req, cpu_rdata, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_model();
    endtask

    task automatic quiet();
        cpu_rd = 0; cpu_wr = 0; cpu_wdata = 8'h00;
        tx_load = 0; tx_last_bit = 0; rx_done = 0;
        rx_frame_err = 0; rx_parity_err = 0; rx_mpbit = 0;
        dma_txd_wr = 0; dma_rxd_rd = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        rst = 0;
        check_word(8'h84, "R1 R2 reset word");
        // R3: zero-write without a prior read leaves flags alone
        cpu_wr = 1; tick(); quiet(); check_word(8'h84, "R3 unarmed write");
        cpu_rd = 1; tick(); quiet();
        cpu_wr = 1; tick(); quiet(); check_word(8'h00, "R4 R5 qualified clear of empty/done");
        tx_load = 1; tick(); quiet(); check_word(8'h80, "R4 load sets empty");
        tx_last_bit = 1; tick(); quiet(); check_word(8'h84, "R5 last bit with empty");
        cpu_wr = 1; cpu_wdata = 8'hFF; tick(); quiet(); check_word(8'h85, "R10 R3 write ones");
        rx_done = 1; rx_mpbit = 1; tick(); quiet(); check_word(8'hC7, "R6 R9 clean frame");
        rx_done = 1; rx_frame_err = 1; rx_parity_err = 1; tick(); quiet();
        check_word(8'hFD, "R7 R8 overrun and faults");
        dma_rxd_rd = 1; tick(); quiet(); check_word(8'hBD, "R6 DMA read clears full");
        cpu_rd = 1; tick(); quiet();
        cpu_wr = 1; cpu_wdata = 8'hC1; tick(); quiet(); check_word(8'h85, "R3 R2 selective clear");
        dma_txd_wr = 1; tick(); quiet(); check_word(8'h01, "R4 R5 DMA write clears");
        tx_last_bit = 1; tick(); quiet(); check_word(8'h01, "R5 last bit without empty");
        tx_load = 1; tick(); quiet();
        cpu_rd = 1; tick(); quiet();
        cpu_wr = 1; cpu_wdata = 8'h01; tx_load = 1; tick(); quiet();
        check_word(8'h81, "R11 set beats clear");
        tx_en = 0; tick(); tx_en = 1; check_word(8'h85, "R4 disabled transmitter");
        tick(); check_word(8'h85, "R4 hold after enable");

        for (int n = 0; n < 4000; n++) begin
            tx_en         = ($urandom_range(0, 19) != 0);
            cpu_rd        = ($urandom_range(0, 9) < 3);
            cpu_wr        = ($urandom_range(0, 9) < 2);
            cpu_wdata     = 8'($urandom);
            tx_load       = ($urandom_range(0, 9) == 0);
            tx_last_bit   = ($urandom_range(0, 9) == 0);
            rx_done       = ($urandom_range(0, 9) < 2);
            rx_frame_err  = ($urandom_range(0, 4) == 0);
            rx_parity_err = ($urandom_range(0, 4) == 0);
            rx_mpbit      = 1'($urandom);
            dma_txd_wr    = ($urandom_range(0, 14) == 0);
            dma_rxd_rd    = ($urandom_range(0, 14) == 0);
            tick();
        end
        quiet();
        tick();
        finish_run();
    end

endmodule